// File: doc/BRIEF.md
# Register File and Add/Subtract Datapath

This block is the arithmetic half of a small 8-bit single-cycle processor. It holds four 8-bit general registers, an adder/subtractor, a 2-bit to 8-bit immediate sign extender and the multiplexors that route operands for the register-register class (add, sub, cmp), the add-immediate class (addi) and the memory class (lw, sw). The surrounding control decoder supplies a handful of control bits. The 8-bit instruction word supplies the register and immediate fields.

The ALU result leaves the block as a write-back value or as a data-memory address. The lower read port leaves it as store data. A compare is a subtraction with the register write disabled, and its outcome appears on the zero and negative flags. Load data from memory enters through its own port and is chosen as write-back data for loads.

Instruction fields seen by this block (bits 7:6 are ignored): in the register and addi classes, bits 5:4 name the destination and upper-port register, bits 3:2 name the lower-port register, and bits 3:2 also carry the addi immediate. In the memory class, bits 1:0 name the base register, bits 3:2 name the data register (load destination or store source), and bits 5:4 carry the offset.

Top module: `regalu_dp`

## Requirements
- R1: While rst_n is low, and after it rises, all four registers read 0 until they are written.
- R2: With reg_write high, the register selected by instr[5:4] (mem_op=0) or by instr[3:2] (mem_op=1) takes the write data on the rising clock edge.
- R3: With reg_write low, no register changes, whatever the other inputs are, including a compare (alu_sub=1).
- R4: Register reads are combinational. store_data always equals the register named by instr[3:2].
- R5: The ALU's first operand is the register named by instr[5:4] when mem_op=0, and by instr[1:0] when mem_op=1.
- R6: The immediate field is instr[3:2] when mem_op=0 and instr[5:4] when mem_op=1. It is read as two's complement (00=0, 01=+1, 10=-2, 11=-1) and sign-extended to 8 bits.
- R7: The ALU's second operand is the extended immediate when use_imm=1, and the lower read port value otherwise.
- R8: alu_y is A+B mod 256 when alu_sub=0, and A-B mod 256 when alu_sub=1.
- R9: The write data is load_data when load_sel=1, and alu_y otherwise.
- R10: flag_z is 1 exactly when alu_y is 0. flag_n equals alu_y[7].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset of the register file |
| instr | input | 8 | Instruction word (fields per description) |
| mem_op | input | 1 | Memory-class instruction: selects base field, offset field and data-register write index |
| use_imm | input | 1 | Second ALU operand is the immediate |
| alu_sub | input | 1 | ALU subtracts instead of adds |
| reg_write | input | 1 | Register write enable |
| load_sel | input | 1 | Write-back data comes from load_data |
| load_data | input | 8 | Data returned by memory for a load |
| alu_y | output | 8 | ALU result (write-back value or memory address) |
| store_data | output | 8 | Lower read port value, used as store data |
| flag_z | output | 1 | ALU result is zero |
| flag_n | output | 1 | ALU result is negative |

## Verification
A corrupted register shows nothing at once. It appears only when a later instruction reads that register, and then it shows combinationally on store_data or through alu_y in that same cycle. The bench therefore reads back every written register within a few instructions. A wrong field select or a wrong extension sign shows as a wrong alu_y in the very cycle the instruction is presented. A spurious write during a compare shows at the next read of that register.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  localparam int DW = 8;
  localparam int AW = 2;
  localparam int IW = 2;

  function automatic logic [DW-1:0] sext_imm(input logic [IW-1:0] f);
    return {{(DW-IW){f[IW-1]}}, f};
  endfunction

  function automatic logic [DW-1:0] addsub(input logic [DW-1:0] a,
                                           input logic [DW-1:0] b,
                                           input logic sub);
    return sub ? (a - b) : (a + b);
  endfunction
endpackage

// File: rtl/regalu_rf.sv
module regalu_rf #(
  parameter int W = 8,
  parameter int A = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [A-1:0] waddr,
  input  logic [W-1:0] wdata,
  input  logic [A-1:0] ra_up,
  input  logic [A-1:0] ra_lo,
  output logic [W-1:0] rd_up,
  output logic [W-1:0] rd_lo
);
  localparam int N = 1 << A;
  logic [N-1:0][W-1:0] q;

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q[i] <= '0;
      else if (we && waddr == A'(i))       q[i] <= wdata;
    end
  end

  assign rd_up = q[ra_up];
  assign rd_lo = q[ra_lo];

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q[$past(waddr)] == $past(wdata));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/regalu_opsel.sv
module regalu_opsel
  import regalu_pkg::*;
(
  input  logic [7:0]    instr,
  input  logic          mem_op,
  input  logic          use_imm,
  input  logic [DW-1:0] rd_lo,
  output logic [AW-1:0] up_idx,
  output logic [AW-1:0] lo_idx,
  output logic [AW-1:0] wr_idx,
  output logic [DW-1:0] imm_ext,
  output logic [DW-1:0] opb
);
  logic [IW-1:0] imm_fld;

  assign up_idx  = mem_op ? instr[1:0] : instr[5:4];
  assign lo_idx  = instr[3:2];
  assign wr_idx  = mem_op ? instr[3:2] : instr[5:4];
  assign imm_fld = mem_op ? instr[5:4] : instr[3:2];
  assign imm_ext = sext_imm(imm_fld);
  assign opb     = use_imm ? imm_ext : rd_lo;

  always_comb begin
    a_r6_ext_uniform: assert (imm_ext[DW-1:IW-1] == '0 || imm_ext[DW-1:IW-1] == '1);
  end
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
(
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] y,
  output logic          z,
  output logic          n
);
  assign y = addsub(a, b, sub);
  assign z = (y == '0);
  assign n = y[DW-1];

  always_comb begin
    a_r10_flags_exclusive: assert (!(z && n));
  end
endmodule

// File: rtl/regalu_dp.sv
module regalu_dp
  import regalu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] instr,
  input  logic       mem_op,
  input  logic       use_imm,
  input  logic       alu_sub,
  input  logic       reg_write,
  input  logic       load_sel,
  input  logic [7:0] load_data,
  output logic [7:0] alu_y,
  output logic [7:0] store_data,
  output logic       flag_z,
  output logic       flag_n
);
  logic [AW-1:0] up_idx, lo_idx, wr_idx;
  logic [DW-1:0] rd_up, rd_lo, imm_ext, opb, wdata;

  regalu_opsel u_sel (
    .instr(instr), .mem_op(mem_op), .use_imm(use_imm), .rd_lo(rd_lo),
    .up_idx(up_idx), .lo_idx(lo_idx), .wr_idx(wr_idx),
    .imm_ext(imm_ext), .opb(opb)
  );

  regalu_rf #(.W(DW), .A(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(reg_write), .waddr(wr_idx), .wdata(wdata),
    .ra_up(up_idx), .ra_lo(lo_idx), .rd_up(rd_up), .rd_lo(rd_lo)
  );

  regalu_alu u_alu (
    .a(rd_up), .b(opb), .sub(alu_sub), .y(alu_y), .z(flag_z), .n(flag_n)
  );

  assign wdata      = load_sel ? load_data : alu_y;
  assign store_data = rd_lo;

  a_r9_load_path: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_write && load_sel && mem_op) |=> store_data == $past(load_data) || $past(instr[3:2]) != instr[3:2]);
  a_r7_reg_operand: assert property (@(posedge clk) disable iff (!rst_n)
    !use_imm |-> opb == store_data);
endmodule

// File: tb/sim_regalu_dp.sv
`timescale 1ns/1ps
module sim_regalu_dp;
  logic clk = 0, rst_n = 0;
  logic [7:0] instr = 0, load_data = 0;
  logic mem_op = 0, use_imm = 0, alu_sub = 0, reg_write = 0, load_sel = 0;
  logic [7:0] alu_y, store_data;
  logic flag_z, flag_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  regalu_dp u0 (.*);

  // {instr, ctrl{mem_op,use_imm,alu_sub,reg_write,load_sel}, load_data, exp_y, exp_sd}
  typedef struct packed {
    logic [7:0] ins; logic [4:0] c; logic [7:0] ld; logic [7:0] ey; logic [7:0] esd;
  } vec_t;
  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{8'h14, 5'b01010, 8'h00, 8'h01, 8'h00},  // addi r1,+1
    '{8'h18, 5'b01010, 8'h00, 8'hFF, 8'h00},  // addi r1,-2
    '{8'h24, 5'b01010, 8'h00, 8'h01, 8'hFF},  // addi r2,+1
    '{8'h18, 5'b00010, 8'h00, 8'h00, 8'h01},  // add r1,r2
    '{8'h24, 5'b00110, 8'h00, 8'h01, 8'h00},  // sub r2,r1
    '{8'h3E, 5'b11011, 8'h5A, 8'h00, 8'h00},  // lw r3,-1(r2)
    '{8'h1F, 5'b11000, 8'h00, 8'h5B, 8'h5A},  // sw r3,+1(r3)
    '{8'h38, 5'b00100, 8'h00, 8'h59, 8'h01},  // cmp r3,r2
    '{8'h2C, 5'b00100, 8'h00, 8'hA7, 8'h5A},  // cmp r2,r3
    '{8'h3C, 5'b00010, 8'h00, 8'hB4, 8'h5A}   // add r3,r3
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [7:0] ins, input logic [4:0] c, input logic [7:0] ld);
    @(negedge clk);
    instr = ins; {mem_op, use_imm, alu_sub, reg_write, load_sel} = c; load_data = ld;
    #1;
  endtask

  task automatic read_reg(input int r, input logic [7:0] exp, input string req);
    drive({4'b0000, r[1:0], 2'b00}, 5'b00000, 8'h00);
    chk(req, store_data, exp);
  endtask

  initial begin
    #1;
    for (int r = 0; r < 4; r++) begin
      instr = {4'b0, r[1:0], 2'b0}; #1;
      chk("R1 reset", store_data, 8'h00);
    end
    repeat (2) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].ins, TBL[i].c, TBL[i].ld);
      chk($sformatf("R5/R6/R7/R8 vec%0d y", i), alu_y, TBL[i].ey);
      chk($sformatf("R4 vec%0d sd", i), store_data, TBL[i].esd);
      chk($sformatf("R10 vec%0d z", i), {7'b0, flag_z}, {7'b0, TBL[i].ey == 8'h00});
      chk($sformatf("R10 vec%0d n", i), {7'b0, flag_n}, {7'b0, TBL[i].ey[7]});
    end
    read_reg(3, 8'hB4, "R2 add writeback");
    read_reg(2, 8'h01, "R3 cmp left r2");
    read_reg(1, 8'h00, "R2 r1");
    // R9 load data written regardless of alu result, mem_op write index [3:2]
    drive(8'h05, 5'b11011, 8'hC3);   // lw r1, 0(r1)
    read_reg(1, 8'hC3, "R9 load writeback");
    read_reg(0, 8'h00, "R2 r0 untouched");
    // R3 write disabled with immediate and load select
    drive(8'h04, 5'b01001, 8'h77);
    drive(8'h04, 5'b01101, 8'h77);
    read_reg(1, 8'hC3, "R3 no write");
    read_reg(0, 8'h00, "R3 r0 no write");
    // R6 offset field [5:4] = 10 -> -2, base r1 via [1:0]
    drive(8'h21, 5'b11000, 8'h00);
    chk("R6 mem offset -2", alu_y, 8'hC1);
    // R8 subtract wrap, R10 negative
    drive(8'h34, 5'b01100, 8'h00);   // r3 - (+1)
    chk("R8 sub imm", alu_y, 8'hB3);
    chk("R10 neg", {7'b0, flag_n}, 8'h01);
    // R1 reset mid-run
    @(negedge clk); rst_n = 0; #1;
    instr = 8'h0C; #1;
    chk("R1 mid reset", store_data, 8'h00);
    @(negedge clk); rst_n = 1;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); errors++; checks++; $display("FAIL watchdog act=timeout exp=done"); end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule